// File: doc/BRIEF.md
# Processor Bus Cycle Controller

This controller links an 8-bit processor bus that uses a status strobe to on-chip memories and a simple port interface. When the strobe `sync` is high, the processor puts a status byte on its data output. The controller decodes that byte into a cycle kind, and it also keeps a registered copy so the kind is still known after the strobe falls. The kind then decides whether the controller returns memory data, port data or an interrupt vector. It also decides whether it writes a memory or a port, and whether it raises `cpu_ready`.

Address bit 13 chooses between two 8 KB memories, and both are reached through external read and write ports. Bits 12:0 form the offset. Writes reach only the upper memory, which is writable, so stores aimed at the lower read-only image are lost. A vector register, loaded from its own port, supplies the byte returned on an interrupt acknowledge. A pending flag records that a vector is waiting. Two flag pulses report a read outside the 16 KB window and a status byte that matches no known cycle kind. A fetch also records its address for observation.

Top module: `cpu_bus_ctrl`

## Requirements
- R1: Status codes: fetch 0xA2, memory read 0x82, stack read 0x86, memory write 0x00, stack write 0x04, input 0x42, output 0x10, interrupt acknowledge 0x23. The kind applies while `sync` is high, and the latched copy keeps applying after `sync` falls until the next strobe.
- R2: For fetch, memory-read and stack-read kinds, `cpu_dout` is set to the read data in the same cycle as the strobe, and `cpu_dout_oe` is high. The read data is `ram_rdata` when address bit 13 is 1 and `rom_rdata` when it is 0. `rom_addr` and `ram_addr` both carry address bits 12:0.
- R3: `ram_we` is high only during a memory-write or stack-write kind while `cpu_wr_n` is low and address bit 13 is 1. It then carries `cpu_din` on `ram_wdata`. A write to an address with bit 13 clear leaves the writable memory unchanged.
- R4: During an input kind, `cpu_dout` equals `io_rdata`, `io_rd` is high and `io_port` equals address bits 7:0.
- R5: During an output kind with `cpu_wr_n` low, `io_wr` is high, `io_wdata` equals `cpu_din` and `io_port` equals address bits 7:0.
- R6: `cpu_ready` is high only while `sync` is high with one of the seven non-acknowledge kinds. It is low at every other time.
- R7: During an interrupt acknowledge, `cpu_dout` carries the stored vector and `cpu_dout_oe` is high.
- R8: A `vec_load` pulse stores `vec_in` and sets `int_pending` from the next cycle on. The flag clears on the edge that ends a strobe cycle carrying the acknowledge code.
- R9: `last_fetch` takes the address of a fetch on the second clock edge after the strobe cycle, and not before.
- R10: `range_err` pulses high for one cycle after a strobe cycle whose kind is a read and whose address is above 0x3FFF. It stays low for 0x3FFF.
- R11: `status_err` pulses high for one cycle after a strobe carrying an unknown code. That strobe does not raise `cpu_ready`.
- R12: `cpu_dout_oe` is low during write and output kinds, including while `cpu_wr_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sync | input | 1 | Status strobe from the processor |
| cpu_din | input | 8 | Processor data output (status or write data) |
| cpu_addr | input | 16 | Processor address |
| cpu_wr_n | input | 1 | Active-low write strobe |
| cpu_dout | output | 8 | Data returned to the processor |
| cpu_dout_oe | output | 1 | Data return enable |
| cpu_ready | output | 1 | Ready to the processor |
| rom_addr | output | 13 | Read-only memory offset |
| rom_rdata | input | 8 | Read-only memory data |
| ram_addr | output | 13 | Writable memory offset |
| ram_rdata | input | 8 | Writable memory read data |
| ram_wdata | output | 8 | Writable memory write data |
| ram_we | output | 1 | Writable memory write enable |
| io_port | output | 8 | Port number |
| io_rdata | input | 8 | Port read data |
| io_wdata | output | 8 | Port write data |
| io_rd | output | 1 | Port read cycle active |
| io_wr | output | 1 | Port write strobe |
| vec_load | input | 1 | Load interrupt vector |
| vec_in | input | 8 | Interrupt vector value |
| int_pending | output | 1 | Vector waiting for acknowledge |
| last_fetch | output | 16 | Address of the latest fetch |
| range_err | output | 1 | Read outside the 16 KB window |
| status_err | output | 1 | Unknown status code seen |

## Verification
The hardest case is a write aimed at the read-only half. That write leaves no trace at the ports except a missing `ram_we`. The stimulus first stores a known byte at a writable address whose low offset matches that of the read-only target. It then sends a stack write to the read-only address and reads the writable address back through a memory-read cycle. In the bench memory model the two addresses share a storage word, so a leaked enable would corrupt the byte that is read back. The two-edge delay of the fetch-address register is also checked on both sides of its update edge.

// File: rtl/cpu_bus_ctrl.sv
module cpu_bus_ctrl #(
  parameter int AW      = 16,
  parameter int DW      = 8,
  parameter int OFS_W   = 13,
  parameter int SEL_BIT = 13,
  parameter int PORT_W  = 8,
  parameter int WIN_TOP = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync,
  input  logic [DW-1:0]     cpu_din,
  input  logic [AW-1:0]     cpu_addr,
  input  logic              cpu_wr_n,
  output logic [DW-1:0]     cpu_dout,
  output logic              cpu_dout_oe,
  output logic              cpu_ready,
  output logic [OFS_W-1:0]  rom_addr,
  input  logic [DW-1:0]     rom_rdata,
  output logic [OFS_W-1:0]  ram_addr,
  input  logic [DW-1:0]     ram_rdata,
  output logic [DW-1:0]     ram_wdata,
  output logic              ram_we,
  output logic [PORT_W-1:0] io_port,
  input  logic [DW-1:0]     io_rdata,
  output logic [DW-1:0]     io_wdata,
  output logic              io_rd,
  output logic              io_wr,
  input  logic              vec_load,
  input  logic [DW-1:0]     vec_in,
  output logic              int_pending,
  output logic [AW-1:0]     last_fetch,
  output logic              range_err,
  output logic              status_err
);

  localparam logic [DW-1:0] ST_FETCH = DW'(8'hA2);
  localparam logic [DW-1:0] ST_MRD   = DW'(8'h82);
  localparam logic [DW-1:0] ST_SRD   = DW'(8'h86);
  localparam logic [DW-1:0] ST_MWR   = DW'(8'h00);
  localparam logic [DW-1:0] ST_SWR   = DW'(8'h04);
  localparam logic [DW-1:0] ST_IN    = DW'(8'h42);
  localparam logic [DW-1:0] ST_OUT   = DW'(8'h10);
  localparam logic [DW-1:0] ST_INTA  = DW'(8'h23);

  typedef enum logic [3:0] {
    CY_NONE, CY_FETCH, CY_MRD, CY_SRD, CY_MWR, CY_SWR, CY_IN, CY_OUT, CY_INTA, CY_BAD
  } cyc_e;

  function automatic cyc_e decode(input logic [DW-1:0] s);
    case (s)
      ST_FETCH: return CY_FETCH;
      ST_MRD:   return CY_MRD;
      ST_SRD:   return CY_SRD;
      ST_MWR:   return CY_MWR;
      ST_SWR:   return CY_SWR;
      ST_IN:    return CY_IN;
      ST_OUT:   return CY_OUT;
      ST_INTA:  return CY_INTA;
      default:  return CY_BAD;
    endcase
  endfunction

  logic [DW-1:0] stat_q;
  logic          stat_vld;
  logic [DW-1:0] vec_q;
  logic [AW-1:0] fa_q;
  logic          fa_v;
  cyc_e          kind;

  assign kind = sync ? decode(cpu_din) : (stat_vld ? decode(stat_q) : CY_NONE);

  logic is_rd, is_wr, is_in, is_out, is_ack;
  assign is_rd  = kind inside {CY_FETCH, CY_MRD, CY_SRD};
  assign is_wr  = kind inside {CY_MWR, CY_SWR};
  assign is_in  = (kind == CY_IN);
  assign is_out = (kind == CY_OUT);
  assign is_ack = (kind == CY_INTA);

  assign rom_addr  = cpu_addr[OFS_W-1:0];
  assign ram_addr  = cpu_addr[OFS_W-1:0];
  assign ram_wdata = cpu_din;
  assign ram_we    = is_wr & ~cpu_wr_n & cpu_addr[SEL_BIT];
  assign io_port   = cpu_addr[PORT_W-1:0];
  assign io_wdata  = cpu_din;
  assign io_rd     = is_in;
  assign io_wr     = is_out & ~cpu_wr_n;

  assign cpu_dout = is_rd  ? (cpu_addr[SEL_BIT] ? ram_rdata : rom_rdata) :
                    is_in  ? io_rdata :
                    is_ack ? vec_q : '0;
  assign cpu_dout_oe = is_rd | is_in | is_ack;
  assign cpu_ready   = sync & (is_rd | is_wr | is_in | is_out);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q      <= '0;
      stat_vld    <= 1'b0;
      vec_q       <= '0;
      int_pending <= 1'b0;
      fa_q        <= '0;
      fa_v        <= 1'b0;
      last_fetch  <= '0;
      range_err   <= 1'b0;
      status_err  <= 1'b0;
    end else begin
      if (sync) begin
        stat_q   <= cpu_din;
        stat_vld <= 1'b1;
      end
      fa_q <= cpu_addr;
      fa_v <= sync & (kind == CY_FETCH);
      if (fa_v) last_fetch <= fa_q;
      range_err  <= sync & is_rd & (|cpu_addr[AW-1:WIN_TOP]);
      status_err <= sync & (kind == CY_BAD);
      if (vec_load) begin
        vec_q       <= vec_in;
        int_pending <= 1'b1;
      end else if (sync && is_ack) begin
        int_pending <= 1'b0;
      end
    end
  end

  a_r6_ready_only_in_sync: assert property (@(posedge clk) disable iff (!rst_n)
    !sync |-> !cpu_ready);
  a_r7_ack_returns_no_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (sync && cpu_din == 8'h23) |-> (!cpu_ready && cpu_dout_oe));
  a_r3_write_only_upper: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (cpu_addr[SEL_BIT] && !cpu_wr_n));
  a_r12_no_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we || io_wr) |-> !cpu_dout_oe);
  a_r8_pending_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (sync && cpu_din == 8'h23 && !vec_load) |=> !int_pending);
  a_r9_fetch_addr_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (sync && cpu_din == 8'hA2) |-> ##2 (last_fetch == $past(cpu_addr, 2)));
  a_r11_bad_code_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (sync && cpu_din == 8'h8A) |=> status_err);

endmodule

// File: tb/cpu_bus_ctrl_tb.sv
module cpu_bus_ctrl_tb;
  logic clk = 0, rst_n = 0;
  logic sync = 0, cpu_wr_n = 1, vec_load = 0;
  logic [7:0] cpu_din = 0, io_rdata = 8'hC3, vec_in = 0;
  logic [15:0] cpu_addr = 0;
  logic [7:0] cpu_dout, rom_rdata, ram_rdata, ram_wdata, io_wdata;
  logic [12:0] rom_addr, ram_addr;
  logic [7:0] io_port;
  logic cpu_dout_oe, cpu_ready, ram_we, io_rd, io_wr, int_pending, range_err, status_err;
  logic [15:0] last_fetch;

  always #10 clk = ~clk;

  cpu_bus_ctrl u_dut (.clk, .rst_n, .sync, .cpu_din, .cpu_addr, .cpu_wr_n, .cpu_dout,
    .cpu_dout_oe, .cpu_ready, .rom_addr, .rom_rdata, .ram_addr, .ram_rdata, .ram_wdata,
    .ram_we, .io_port, .io_rdata, .io_wdata, .io_rd, .io_wr, .vec_load, .vec_in,
    .int_pending, .last_fetch, .range_err, .status_err);

  function automatic logic [7:0] rom_byte(input logic [12:0] a);
    return a[7:0] ^ {3'b0, a[12:8]} ^ 8'h5C;
  endfunction
  assign rom_rdata = rom_byte(rom_addr);

  logic [7:0] ram_m [256];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) ram_m[i] <= 8'h00;
    end else if (ram_we) ram_m[ram_addr[7:0]] <= ram_wdata;
  end
  assign ram_rdata = ram_m[ram_addr[7:0]];

  typedef struct { string tag; logic [15:0] act; logic [15:0] exp; } item_t;
  item_t sb_q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    item_t it;
    it.tag = tag; it.act = act; it.exp = exp;
    sb_q.push_back(it);
  endtask

  always @(posedge clk) begin
    while (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      n_chk++;
      if (it.act !== it.exp) begin
        n_fail++;
        $display("FAIL %s actual=%h expected=%h", it.tag, it.act, it.exp);
      end
    end
  end

  task automatic step(input logic s, input logic [7:0] d, input logic [15:0] a, input logic w);
    @(negedge clk);
    sync = s; cpu_din = d; cpu_addr = a; cpu_wr_n = w;
    #5;
  endtask

  task automatic finish_run();
    @(posedge clk); @(posedge clk);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    step(0, 8'h00, 16'h0000, 1);
    chk("R6 reset ready", cpu_ready, 0);
    chk("R1 reset oe", cpu_dout_oe, 0);
    chk("R8 reset pending", int_pending, 0);
    chk("R9 reset last_fetch", last_fetch, 16'h0000);
    chk("R10 reset range", range_err, 0);

    // fetch from read-only half
    step(1, 8'hA2, 16'h0123, 1);
    chk("R6 fetch ready", cpu_ready, 1);
    chk("R2 fetch data", cpu_dout, rom_byte(13'h0123));
    chk("R2 rom offset", rom_addr, 16'h0123);
    chk("R2 fetch oe", cpu_dout_oe, 1);
    step(0, 8'h00, 16'h0123, 1);
    chk("R1 latched kind keeps oe", cpu_dout_oe, 1);
    chk("R6 ready drops after sync", cpu_ready, 0);
    chk("R9 not after one edge", last_fetch, 16'h0000);
    step(0, 8'h00, 16'h0000, 1);
    chk("R9 fetch addr after two edges", last_fetch, 16'h0123);

    // memory write to writable half
    step(1, 8'h00, 16'h2040, 1);
    chk("R6 write ready", cpu_ready, 1);
    chk("R12 write strobe oe", cpu_dout_oe, 0);
    step(0, 8'h5A, 16'h2040, 0);
    chk("R3 write enable", ram_we, 1);
    chk("R3 write data", ram_wdata, 8'h5A);
    chk("R3 ram offset", ram_addr, 16'h0040);
    chk("R12 oe during write", cpu_dout_oe, 0);
    step(0, 8'h00, 16'h2040, 1);
    chk("R3 enable gone with strobe high", ram_we, 0);

    // memory read back
    step(1, 8'h82, 16'h2040, 1);
    chk("R2 ram read", cpu_dout, 8'h5A);
    step(0, 8'h00, 16'h0000, 1);

    // stack write to read-only half must be dropped
    step(1, 8'h04, 16'h0040, 1);
    step(0, 8'hEE, 16'h0040, 0);
    chk("R3 rom-region write dropped", ram_we, 0);
    step(0, 8'h00, 16'h0040, 1);
    step(1, 8'h86, 16'h0040, 1);
    chk("R2 stack read rom", cpu_dout, rom_byte(13'h0040));
    step(1, 8'h82, 16'h2040, 1);
    chk("R3 ram unchanged", cpu_dout, 8'h5A);

    // input
    step(1, 8'h42, 16'h1237, 1);
    chk("R4 input data", cpu_dout, 8'hC3);
    chk("R4 input port", io_port, 16'h0037);
    chk("R4 input strobe", io_rd, 1);
    chk("R6 input ready", cpu_ready, 1);

    // output
    step(1, 8'h10, 16'h00A5, 1);
    chk("R6 output ready", cpu_ready, 1);
    chk("R5 no write before strobe", io_wr, 0);
    step(0, 8'h99, 16'h00A5, 0);
    chk("R5 output write", io_wr, 1);
    chk("R5 output data", io_wdata, 8'h99);
    chk("R5 output port", io_port, 16'h00A5);
    chk("R12 oe during output", cpu_dout_oe, 0);
    step(0, 8'h00, 16'h0000, 1);

    // interrupt vector and acknowledge
    @(negedge clk); vec_in = 8'hFF; vec_load = 1;
    @(negedge clk); vec_load = 0; #5;
    chk("R8 pending set", int_pending, 1);
    step(1, 8'h23, 16'h0000, 1);
    chk("R7 vector data", cpu_dout, 8'hFF);
    chk("R7 vector oe", cpu_dout_oe, 1);
    chk("R6 no ready on ack", cpu_ready, 0);
    chk("R8 pending until edge", int_pending, 1);
    step(0, 8'h00, 16'h0000, 1);
    chk("R8 pending cleared", int_pending, 0);

    // address window
    step(1, 8'h82, 16'h4001, 1);
    step(0, 8'h00, 16'h0000, 1);
    chk("R10 out of window read", range_err, 1);
    step(1, 8'hA2, 16'h3FFF, 1);
    step(0, 8'h00, 16'h0000, 1);
    chk("R10 top of window ok", range_err, 0);
    step(1, 8'h00, 16'h8000, 1);
    step(0, 8'h00, 16'h0000, 1);
    chk("R10 write not flagged", range_err, 0);

    // unknown code
    step(1, 8'h8A, 16'h0000, 1);
    chk("R11 no ready on bad code", cpu_ready, 0);
    step(0, 8'h00, 16'h0000, 1);
    chk("R11 bad code flag", status_err, 1);
    step(0, 8'h00, 16'h0000, 1);
    chk("R11 flag is a pulse", status_err, 0);

    finish_run();
  end
endmodule